// File: doc/BRIEF.md
# Interrupt Status Aggregation Unit

This block gathers event pulses from a network peripheral's receive and transmit datapaths, together with a wakeup event, into one 16-bit sticky status word. It drives a single level-sensitive interrupt request to the CPU. The request is high while any status bit is also enabled in a mask register. Software reads the status word to find what raised the request. It sets bits by writing ones to a set register and clears them by writing ones to a clear register.

Hardware events can only raise status bits. Bit 12 is a soft-interrupt bit with no hardware input, provided so that software can test the interrupt path. Writes to the set, clear and enable registers are not posted. The acknowledge returns in the cycle after the request, and by then the register is already updated and the interrupt output already reflects the change.

Top module: `isr_aggregator`

## Requirements
- R1: `irq_o` is a registered level that is high exactly when (status AND enable) is non-zero. It takes its new value on the same clock edge that changes status or enable.
- R2: Reading address 0 returns the status word. The bit positions are: rx overrun 0, rx error 1, rx finished 2, rx done 3, tx underrun 4, tx error 5, tx finished 6, tx done 7, soft 12, wakeup 13. All other bits are reserved and always read 0.
- R3: Writing to address 3 (set) sets each status bit whose write-data bit is 1 and leaves the other bits unchanged.
- R4: Writing to address 2 (clear) clears each status bit whose write-data bit is 1 and leaves the other bits unchanged.
- R5: A one-cycle pulse on a hardware event input sets its status bit at the next edge. Hardware inputs never clear a bit. If a hardware set and a software clear reach the same bit in the same cycle, the bit ends up set.
- R6: Status bit 12 (soft) is set only through the set register. No combination of hardware inputs sets it.
- R7: Address 1 is the enable mask. It is readable and writable, and its reserved bits always read 0.
- R8: After reset, status, enable, `irq_o`, `ack_o` and `rdata_o` are all zero.
- R9: Every request is acknowledged with a one-cycle `ack_o` in the cycle after `req_i`. For writes, the register and `irq_o` already hold their new values when `ack_o` is high. For reads, `rdata_o` is valid while `ack_o` is high.
- R10: A write to the status address has no effect. A read of the set or clear address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe, one cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | 0 status, 1 enable, 2 clear, 3 set |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid while ack_o is high |
| ack_o | output | 1 | Access complete |
| rx_evt_i | input | 4 | Receive events: overrun, error, finished, done (bits 0..3) |
| tx_evt_i | input | 4 | Transmit events: underrun, error, finished, done (bits 0..3) |
| wake_evt_i | input | 1 | Wakeup event |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
Every result is due one edge after its stimulus. A register write or a hardware event pulse changes the status, the mask and `irq_o` at the edge that samples it. `ack_o` and the read data appear on that same edge. The bench drives each stimulus at a falling edge and samples one time unit after the following rising edge. It therefore observes `irq_o` in the acknowledge cycle of each write, which checks that the write is non-posted. Status contents are confirmed afterwards through separate reads.

// File: rtl/isr_pkg.sv
package isr_pkg;
  localparam int unsigned STAT_W = 16;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned RX_N   = 4;
  localparam int unsigned TX_N   = 4;
  localparam int unsigned RX_LSB = 0;
  localparam int unsigned TX_LSB = RX_LSB + RX_N;
  localparam int unsigned SOFT_B = 12;
  localparam int unsigned WAKE_B = 13;

  localparam logic [STAT_W-1:0] HW_MASK =
    STAT_W'(((1 << (RX_N + TX_N)) - 1) << RX_LSB) | (STAT_W'(1) << WAKE_B);
  localparam logic [STAT_W-1:0] VALID_MASK = HW_MASK | (STAT_W'(1) << SOFT_B);

  typedef enum logic [ADDR_W-1:0] {
    REG_STAT = 2'd0,
    REG_EN   = 2'd1,
    REG_CLR  = 2'd2,
    REG_SET  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/isr_status_bank.sv
module isr_status_bank
  import isr_pkg::*;
#(
  parameter int unsigned W = STAT_W,
  parameter logic [W-1:0] VALID = VALID_MASK
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] hw_set_i,
  input  logic [W-1:0] sw_set_i,
  input  logic [W-1:0] sw_clr_i,
  output logic [W-1:0] stat_d_o,
  output logic [W-1:0] stat_q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (VALID[i]) begin : g_live
      logic q;
      // set beats clear so a coincident event is kept
      assign stat_d_o[i] = hw_set_i[i] | sw_set_i[i] | (q & ~sw_clr_i[i]);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= 1'b0;
        else         q <= stat_d_o[i];
      end
      assign stat_q_o[i] = q;
    end else begin : g_rsvd
      assign stat_d_o[i] = 1'b0;
      assign stat_q_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/isr_mask_reg.sv
module isr_mask_reg
  import isr_pkg::*;
#(
  parameter int unsigned W = STAT_W,
  parameter logic [W-1:0] VALID = VALID_MASK
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] en_d_o,
  output logic [W-1:0] en_q_o
);
  logic [W-1:0] en_q;
  assign en_d_o = we_i ? (wdata_i & VALID) : en_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= en_d_o;
  end
  assign en_q_o = en_q;
endmodule

// File: rtl/isr_bus_port.sv
module isr_bus_port
  import isr_pkg::*;
#(
  parameter int unsigned W  = STAT_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [W-1:0]  stat_i,
  input  logic [W-1:0]  en_i,
  output logic [W-1:0]  sw_set_o,
  output logic [W-1:0]  sw_clr_o,
  output logic          en_we_o,
  output logic [W-1:0]  rdata_o,
  output logic          ack_o
);
  logic wr, rd;
  logic [W-1:0] rd_mux;
  logic [W-1:0] rdata_q;
  logic         ack_q;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  assign sw_set_o = (wr && addr_i == REG_SET) ? wdata_i : '0;
  assign sw_clr_o = (wr && addr_i == REG_CLR) ? wdata_i : '0;
  assign en_we_o  = wr && addr_i == REG_EN;

  always_comb begin
    unique case (addr_i)
      REG_STAT: rd_mux = stat_i;
      REG_EN:   rd_mux = en_i;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q   <= req_i;
      rdata_q <= rd ? rd_mux : '0;
    end
  end

  assign ack_o   = ack_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/isr_aggregator.sv
module isr_aggregator
  import isr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [STAT_W-1:0] wdata_i,
  output logic [STAT_W-1:0] rdata_o,
  output logic              ack_o,
  input  logic [RX_N-1:0]   rx_evt_i,
  input  logic [TX_N-1:0]   tx_evt_i,
  input  logic              wake_evt_i,
  output logic              irq_o
);
  logic [STAT_W-1:0] hw_set, sw_set, sw_clr;
  logic [STAT_W-1:0] stat_d, stat_q, en_d, en_q;
  logic              en_we;
  logic              irq_q;

  always_comb begin
    hw_set = '0;
    hw_set[RX_LSB +: RX_N] = rx_evt_i;
    hw_set[TX_LSB +: TX_N] = tx_evt_i;
    hw_set[WAKE_B]         = wake_evt_i;
  end

  isr_bus_port u_port (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .stat_i(stat_q), .en_i(en_q),
    .sw_set_o(sw_set), .sw_clr_o(sw_clr), .en_we_o(en_we),
    .rdata_o, .ack_o
  );

  isr_status_bank u_stat (
    .clk_i, .rst_ni, .hw_set_i(hw_set & HW_MASK),
    .sw_set_i(sw_set), .sw_clr_i(sw_clr),
    .stat_d_o(stat_d), .stat_q_o(stat_q)
  );

  isr_mask_reg u_mask (
    .clk_i, .rst_ni, .we_i(en_we), .wdata_i,
    .en_d_o(en_d), .en_q_o(en_q)
  );

  // registered from next-state values: glitch free, no extra latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(stat_d & en_d);
  end
  assign irq_o = irq_q;
endmodule

// File: rtl/isr_aggregator_chk.sv
module isr_aggregator_chk
  import isr_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [STAT_W-1:0] wdata_i,
  input logic              ack_o,
  input logic [RX_N-1:0]   rx_evt_i,
  input logic [TX_N-1:0]   tx_evt_i,
  input logic              wake_evt_i,
  input logic              irq_o,
  input logic [STAT_W-1:0] stat_q,
  input logic [STAT_W-1:0] en_q
);
  logic [STAT_W-1:0] hw_vec;
  always_comb begin
    hw_vec = '0;
    hw_vec[RX_LSB +: RX_N] = rx_evt_i;
    hw_vec[TX_LSB +: TX_N] = tx_evt_i;
    hw_vec[WAKE_B]         = wake_evt_i;
  end

  AST_IRQ_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == |(stat_q & en_q)); // R1
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_q | en_q) & ~VALID_MASK) == '0); // R2
  AST_HW_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hw_vec) |=> ((stat_q & $past(hw_vec)) == $past(hw_vec))); // R5
  AST_FALL_NEEDS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~stat_q & $past(stat_q)) != '0) |-> $past(req_i && we_i && addr_i == REG_CLR)); // R5
  AST_SOFT_SW_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_q[SOFT_B]) |-> $past(req_i && we_i && addr_i == REG_SET && wdata_i[SOFT_B])); // R6
  AST_ACK_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> ack_o); // R9
  AST_ACK_ONLY_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(req_i)); // R9
endmodule

bind isr_aggregator isr_aggregator_chk u_chk (
  .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .ack_o,
  .rx_evt_i, .tx_evt_i, .wake_evt_i, .irq_o,
  .stat_q, .en_q
);

// File: tb/isr_aggregator_test.sv
module isr_aggregator_test;
  localparam int CLK_P = 10;
  localparam logic [15:0] VALID = 16'h30FF;

  logic        clk_i = 0, rst_ni = 0;
  logic        req_i = 0, we_i = 0;
  logic [1:0]  addr_i = 0;
  logic [15:0] wdata_i = 0;
  logic [15:0] rdata_o;
  logic        ack_o, irq_o;
  logic [3:0]  rx_evt_i = 0, tx_evt_i = 0;
  logic        wake_evt_i = 0;

  int errs = 0, checks = 0;
  logic done = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  isr_aggregator uut (.*);

  task automatic chk(string r, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // drive at negedge, sample 1 after the next posedge
  task automatic acc(input logic w, input logic [1:0] a, input logic [15:0] d,
                     input logic [3:0] rx, input logic [3:0] tx, input logic wk,
                     output logic [15:0] rd, output logic ak, output logic iq);
    @(negedge clk_i);
    req_i = 1; we_i = w; addr_i = a; wdata_i = d;
    rx_evt_i = rx; tx_evt_i = tx; wake_evt_i = wk;
    @(posedge clk_i); #1;
    req_i = 0; we_i = 0; wdata_i = 0; rx_evt_i = 0; tx_evt_i = 0; wake_evt_i = 0;
    rd = rdata_o; ak = ack_o; iq = irq_o;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d, output logic iq);
    logic [15:0] rd; logic ak;
    acc(1, a, d, 0, 0, 0, rd, ak, iq);
    chk("R9 write ack", {15'b0, ak}, 16'h1);
  endtask

  task automatic rdreg(input logic [1:0] a, output logic [15:0] rd);
    logic ak, iq;
    acc(0, a, 0, 0, 0, 0, rd, ak, iq);
    chk("R9 read ack", {15'b0, ak}, 16'h1);
  endtask

  task automatic evt(input logic [3:0] rx, input logic [3:0] tx, input logic wk, output logic iq);
    @(negedge clk_i);
    rx_evt_i = rx; tx_evt_i = tx; wake_evt_i = wk;
    @(posedge clk_i); #1;
    rx_evt_i = 0; tx_evt_i = 0; wake_evt_i = 0;
    iq = irq_o;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd; logic iq, ak;
    repeat (3) @(posedge clk_i);
    #1;
    chk("R8 rdata", rdata_o, 0);
    chk("R8 ack/irq", {14'b0, ack_o, irq_o}, 0);
    rst_ni = 1;
    rdreg(0, rd); chk("R8 status", rd, 0);
    rdreg(1, rd); chk("R8 enable", rd, 0);

    // R3 R4 R2: walk every bit through set/clear with mask off
    for (int i = 0; i < 16; i++) begin
      wr(3, 16'h1 << i, iq);
      chk("R1 masked irq", {15'b0, iq}, 0);
      rdreg(0, rd); chk("R3 R2 set bit", rd, (16'h1 << i) & VALID);
      wr(2, 16'h1 << i, iq);
      rdreg(0, rd); chk("R4 clear bit", rd, 0);
    end

    // R3 R4 partial patterns leave other bits alone
    wr(3, 16'hFFFF, iq);
    wr(2, 16'h00F0, iq);
    rdreg(0, rd); chk("R4 partial clear", rd, VALID & ~16'h00F0);
    wr(3, 16'h0050, iq);
    rdreg(0, rd); chk("R3 partial set", rd, (VALID & ~16'h00F0) | 16'h0050);

    // R10: status write ignored, WO regs read zero
    wr(0, 16'h0000, iq);
    rdreg(0, rd); chk("R10 status write ignored", rd, (VALID & ~16'h00F0) | 16'h0050);
    rdreg(2, rd); chk("R10 clear reads 0", rd, 0);
    rdreg(3, rd); chk("R10 set reads 0", rd, 0);
    wr(2, 16'hFFFF, iq);

    // R7 enable reserved bits
    wr(1, 16'hFFFF, iq);
    rdreg(1, rd); chk("R7 enable readback", rd, VALID);
    wr(1, 16'h0000, iq);

    // R1 R9: irq visible in the ack cycle of non-posted writes
    for (int i = 0; i < 16; i++) begin
      if (VALID[i]) begin
        wr(1, 16'h1 << i, iq); chk("R1 enable only", {15'b0, iq}, 0);
        wr(3, 16'h1 << i, iq); chk("R9 R1 irq at set ack", {15'b0, iq}, 1);
        wr(1, 16'h0, iq);      chk("R9 R1 irq at mask ack", {15'b0, iq}, 0);
        wr(1, 16'h1 << i, iq); chk("R9 R1 irq at unmask ack", {15'b0, iq}, 1);
        wr(2, 16'h1 << i, iq); chk("R9 R1 irq at clear ack", {15'b0, iq}, 0);
      end
    end
    wr(1, 16'h0, iq);

    // R5: every rx/tx event pattern
    for (int p = 0; p < 16; p++) begin
      evt(p[3:0], 0, 0, iq);
      rdreg(0, rd); chk("R5 rx events", rd, 16'(p));
      evt(0, p[3:0], 0, iq);
      rdreg(0, rd); chk("R5 tx events accumulate", rd, 16'(p) | 16'(p << 4));
      evt(0, 0, 0, iq);
      rdreg(0, rd); chk("R5 hw idle never clears", rd, 16'(p) | 16'(p << 4));
      wr(2, 16'hFFFF, iq);
    end
    evt(0, 0, 1, iq);
    rdreg(0, rd); chk("R5 wake event", rd, 16'h2000);
    wr(2, 16'hFFFF, iq);

    // R6: all hw inputs high never set soft bit
    evt(4'hF, 4'hF, 1, iq);
    rdreg(0, rd); chk("R6 soft untouched by hw", rd, 16'h20FF);
    wr(3, 16'h1000, iq);
    rdreg(0, rd); chk("R6 soft by sw", rd, 16'h30FF);
    wr(2, 16'hFFFF, iq);

    // R5 collision: hw set beats sw clear
    acc(1, 2, 16'h0003, 4'h1, 0, 0, rd, ak, iq);
    chk("R9 collision ack", {15'b0, ak}, 1);
    rdreg(0, rd); chk("R5 set wins", rd, 16'h0001);
    wr(2, 16'hFFFF, iq);

    // R1: hw event raises irq on the sampling edge
    wr(1, 16'h0020, iq);
    evt(0, 4'h2, 0, iq); chk("R1 irq on hw event", {15'b0, iq}, 1);
    evt(0, 0, 0, iq);    chk("R1 irq held", {15'b0, iq}, 1);
    wr(2, 16'h0020, iq); chk("R1 irq dropped", {15'b0, iq}, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule